// File: doc/BRIEF.md
# Spike-Timing Learning Controller for One Synapse Column

This block controls the learning feedback for a single column of a synaptic crossbar. A millisecond timebase runs from the global clock. For every row of the column the block stores the time of the most recent pre-synaptic spike. When the column's neuron fires, the block takes the fire time and computes one signed interval for each row. It turns each interval into a feedback pulse, either potentiating or depressing, with a fixed length. It then drives one enable per row for that many cycles. While this feedback runs, the pause flag stays high. The pause flag tells the input side to hold off new spikes.

For each row the interval is measured against two fire events. A spike recorded before the current fire is a candidate for potentiation, measured as fire time minus spike time. The same spike, measured from the previous fire, is a candidate for depression. The closer pairing decides the polarity. The interval magnitude goes to the nearest point of a four-entry table. Shorter intervals give longer pulses, and magnitudes beyond the window give no pulse. All inputs are plain single-cycle strobes. The block has no data stream, so there is no valid/ready handshake and no back-pressure. While the pause flag is high, strobes are dropped, not stalled.

Top module: `stdp_column_learn`

## Requirements
- R1: During and right after reset, every potentiate enable, every depress enable and the pause flag are low.
- R2: Polarity. Let P be the distance in ms from the row's stored spike to the new fire. Let D be the distance from the previous fire to that spike. The row is potentiated when P <= D or when no fire has happened since reset. Otherwise it is depressed, with magnitude D.
- R3: Pulse length. Timestamps advance once every TICK_CYC clock cycles. A magnitude of 0–15 ms gives 200 ms. A magnitude of 16–25 ms gives 100 ms, 26–35 ms gives 50 ms and 36–40 ms gives 20 ms. A pulse of W ms holds its enable high for exactly W*TICK_CYC cycles, starting in the cycle after the fire strobe is accepted.
- R4: A row with a magnitude above 40 ms, or with no spike recorded since the last learning event, gets no pulse.
- R5: On every row, the potentiate and depress enables are never high in the same cycle.
- R6: The pause flag rises in the cycle after an accepted fire strobe. It falls in the cycle after the last enable of the column drops, so it is high for Wmax*TICK_CYC+1 cycles, or for 1 cycle when no row gets a pulse.
- R7: A row spike strobe that arrives while the pause flag is high is not recorded.
- R8: A fire strobe that arrives while the pause flag is high starts no new learning event and does not lengthen the current one.
- R9: Each learning event clears all stored spikes. When a row spikes more than once before a fire, only its latest spike counts.
- R10: A row spike in the same cycle as an accepted fire strobe counts as an interval of 0 ms and gives a 200 ms potentiation.
- R11: The timestamp wraps modulo 2^TS_W. Intervals that cross the wrap are measured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| row_spike_i | input | N_ROWS | Per-row pre-synaptic spike strobe, one cycle |
| post_fire_i | input | 1 | Column neuron fire strobe, one cycle |
| pot_en_o | output | N_ROWS | Per-row potentiating pulse enable |
| dep_en_o | output | N_ROWS | Per-row depressing pulse enable |
| pause_o | output | 1 | High while feedback is being applied; inputs are held off |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is capturing a row spike and accepting the fire. The bench drives a spike strobe and the fire strobe on the same edge. It expects a zero-interval, full-length potentiation on that row only. The second pair is counting down the feedback pulses and receiving a new fire or spike. The bench injects a fire strobe and a spike strobe halfway through a long feedback phase. It then checks that the pause length matches the original event exactly. A fire strobe right after release must then find no stored spikes and produce no pulse.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
  localparam int unsigned STEP_MS   = 10;
  localparam int unsigned N_BINS    = 4;
  localparam int unsigned WIN_MS    = STEP_MS * N_BINS;
  localparam int unsigned PW_W      = 8;
  localparam int unsigned PW_MAX_MS = 200;

  // Feedback length per interval bin; nearer pairings drive longer pulses.
  function automatic logic [PW_W-1:0] bin_ms(input int unsigned b);
    case (b)
      0:       return 8'd200;
      1:       return 8'd100;
      2:       return 8'd50;
      default: return 8'd20;
    endcase
  endfunction

  // Round magnitude to nearest table point; outside the window gives zero.
  function automatic logic [PW_W-1:0] pulse_ms(input int unsigned mag);
    logic [PW_W-1:0] w;
    logic            hit;
    w   = '0;
    hit = 1'b0;
    if (mag <= WIN_MS) begin
      for (int unsigned b = 0; b < N_BINS; b++) begin
        if (!hit && mag <= STEP_MS * (b + 1) + STEP_MS / 2) begin
          w   = bin_ms(b);
          hit = 1'b1;
        end
      end
      if (!hit) w = bin_ms(N_BINS - 1);
    end
    return w;
  endfunction
endpackage

// File: rtl/stdp_timebase.sv
module stdp_timebase #(
  parameter int unsigned TS_W     = 12,
  parameter int unsigned TICK_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  localparam int unsigned PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [PW-1:0]   pre_q;
  logic [TS_W-1:0] ts_q;
  logic            last;

  assign last = (pre_q == PW'(TICK_CYC - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ts_q  <= '0;
    end else if (last) begin
      pre_q <= '0;
      ts_q  <= ts_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/stdp_row_lane.sv
module stdp_row_lane
  import stdp_pkg::*;
#(
  parameter int unsigned TS_W     = 12,
  parameter int unsigned TICK_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TS_W-1:0] ts_i,
  input  logic            spike_i,
  input  logic            open_i,
  input  logic            learn_i,
  input  logic [TS_W-1:0] prev_ts_i,
  input  logic            prev_ok_i,
  output logic            pot_o,
  output logic            dep_o,
  output logic            busy_o
);
  localparam int unsigned CW = $clog2(PW_MAX_MS * TICK_CYC + 1);

  logic [TS_W-1:0] arr_q;
  logic            arr_ok_q;
  logic [CW-1:0]   cnt_q;
  logic            pol_q;

  logic            take_now;
  logic [TS_W-1:0] eff_ts;
  logic            eff_ok;
  logic [TS_W-1:0] d_pos;
  logic [TS_W-1:0] d_neg;
  logic [TS_W-1:0] mag;
  logic            use_dep;
  logic [PW_W-1:0] pw;

  always_comb begin
    take_now = open_i & spike_i;
    eff_ts   = take_now ? ts_i : arr_q;
    eff_ok   = take_now | arr_ok_q;
    d_pos    = ts_i - eff_ts;          // modular, valid across wrap
    d_neg    = eff_ts - prev_ts_i;
    use_dep  = prev_ok_i && (d_neg < d_pos);
    mag      = use_dep ? d_neg : d_pos;
    pw       = eff_ok ? pulse_ms(32'(mag)) : '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      arr_q    <= '0;
      arr_ok_q <= 1'b0;
      cnt_q    <= '0;
      pol_q    <= 1'b0;
    end else if (learn_i) begin
      arr_ok_q <= 1'b0;
      cnt_q    <= CW'(32'(pw) * TICK_CYC);
      pol_q    <= ~use_dep;
    end else begin
      if (take_now) begin
        arr_q    <= ts_i;
        arr_ok_q <= 1'b1;
      end
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign pot_o  = busy_o & pol_q;
  assign dep_o  = busy_o & ~pol_q;
endmodule

// File: rtl/stdp_column_learn.sv
module stdp_column_learn #(
  parameter int unsigned N_ROWS   = 16,
  parameter int unsigned TS_W     = 12,
  parameter int unsigned TICK_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ROWS-1:0] row_spike_i,
  input  logic              post_fire_i,
  output logic [N_ROWS-1:0] pot_en_o,
  output logic [N_ROWS-1:0] dep_en_o,
  output logic              pause_o
);
  logic [TS_W-1:0]   ts;
  logic [TS_W-1:0]   prev_ts_q;
  logic              prev_ok_q;
  logic              pause_q;
  logic              learn;
  logic [N_ROWS-1:0] busy;

  assign learn = post_fire_i & ~pause_q;

  stdp_timebase #(.TS_W(TS_W), .TICK_CYC(TICK_CYC)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ts_o   (ts)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pause_q   <= 1'b0;
      prev_ts_q <= '0;
      prev_ok_q <= 1'b0;
    end else if (learn) begin
      pause_q   <= 1'b1;
      prev_ts_q <= ts;
      prev_ok_q <= 1'b1;
    end else if (pause_q && busy == '0) begin
      pause_q   <= 1'b0;
    end
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    stdp_row_lane #(.TS_W(TS_W), .TICK_CYC(TICK_CYC)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ts_i      (ts),
      .spike_i   (row_spike_i[r]),
      .open_i    (~pause_q),
      .learn_i   (learn),
      .prev_ts_i (prev_ts_q),
      .prev_ok_i (prev_ok_q),
      .pot_o     (pot_en_o[r]),
      .dep_o     (dep_en_o[r]),
      .busy_o    (busy[r])
    );
  end

  assign pause_o = pause_q;
endmodule

// File: rtl/stdp_column_chk.sv
module stdp_column_chk #(
  parameter int unsigned N_ROWS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              post_fire_i,
  input logic [N_ROWS-1:0] pot_en_o,
  input logic [N_ROWS-1:0] dep_en_o,
  input logic              pause_o
);
  logic [N_ROWS-1:0] any_en;
  assign any_en = pot_en_o | dep_en_o;

  // R5
  excl_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pot_en_o & dep_en_o) == '0);

  // R6
  en_in_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_en != '0) |-> pause_o);

  // R6
  fire_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_fire_i && !pause_o) |=> pause_o);

  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o && any_en == '0) |=> !pause_o);

  // R8
  start_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((any_en & ~$past(any_en)) != '0) |-> $rose(pause_o));
endmodule

bind stdp_column_learn stdp_column_chk #(.N_ROWS(N_ROWS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .post_fire_i (post_fire_i),
  .pot_en_o    (pot_en_o),
  .dep_en_o    (dep_en_o),
  .pause_o     (pause_o)
);

// File: tb/test_stdp_column_learn.sv
module test_stdp_column_learn;
  localparam int NR  = 4;
  localparam int TSW = 8;
  localparam int TK  = 4;
  localparam int NV  = 14;

  typedef struct packed { int g1; int g2; int pot; int dep; } vec_t;
  // g1: ms from previous fire to spike, g2: ms from spike to fire (0 = same cycle)
  localparam vec_t VECS [NV] = '{
    '{50, 10, 200,   0}, '{50, 20, 100,   0}, '{50, 30,  50,   0},
    '{50, 40,  20,   0}, '{50, 41,   0,   0}, '{50, 15, 200,   0},
    '{50, 16, 100,   0}, '{50,  0, 200,   0}, '{10, 50,   0, 200},
    '{25, 30,   0, 100}, '{36, 45,   0,  20}, '{30, 30,  50,   0},
    '{45, 45,   0,   0}, '{50, 25, 100,   0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] row_spike = '0;
  logic          post_fire = 1'b0;
  logic [NR-1:0] pot_en_o;
  logic [NR-1:0] dep_en_o;
  logic          pause_o;

  int errors = 0;
  int checks = 0;
  int edges  = 0;
  int pot_n [NR];
  int dep_n [NR];
  int both_n;
  int pause_n;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  stdp_column_learn #(.N_ROWS(NR), .TS_W(TSW), .TICK_CYC(TK)) i_stdp_column_learn (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .row_spike_i (row_spike),
    .post_fire_i (post_fire),
    .pot_en_o    (pot_en_o),
    .dep_en_o    (dep_en_o),
    .pause_o     (pause_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Fire now (with optional same-cycle spikes), then record the whole pause phase.
  task automatic run_phase(input logic [NR-1:0] same_spk, input int fire_at,
                           input int spike_at, input int spike_row);
    row_spike = same_spk;
    post_fire = 1'b1;
    @(negedge clk);
    row_spike = '0;
    post_fire = 1'b0;
    pause_n = 0;
    both_n  = 0;
    for (int r = 0; r < NR; r++) begin pot_n[r] = 0; dep_n[r] = 0; end
    for (int idx = 0; idx < 4000 && pause_o; idx++) begin
      pause_n++;
      for (int r = 0; r < NR; r++) begin
        if (pot_en_o[r]) pot_n[r]++;
        if (dep_en_o[r]) dep_n[r]++;
      end
      if ((pot_en_o & dep_en_o) != '0) both_n++;
      post_fire = (idx == fire_at);
      row_spike = '0;
      if (idx == spike_at && spike_row >= 0) row_spike[spike_row] = 1'b1;
      @(negedge clk);
    end
    post_fire = 1'b0;
    row_spike = '0;
  endtask

  task automatic spike_wait(input int row, input int ms);
    row_spike[row] = 1'b1;
    @(negedge clk);
    row_spike = '0;
    repeat (ms * TK - 1) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int row;
    int w;
    int sum;
    repeat (4) @(negedge clk);
    // R1 outputs during reset
    check("R1 pause in reset", int'(pause_o), 0);
    check("R1 enables in reset", int'(pot_en_o | dep_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'({pause_o, pot_en_o, dep_en_o}), 0);

    // Vector table: R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      row = i % NR;
      run_phase('0, -1, -1, -1);
      repeat (VECS[i].g1 * TK - 2) @(negedge clk);
      if (VECS[i].g2 == 0) begin
        run_phase(NR'(1) << row, -1, -1, -1);
      end else begin
        spike_wait(row, VECS[i].g2);
        run_phase('0, -1, -1, -1);
      end
      w = (VECS[i].pot > VECS[i].dep) ? VECS[i].pot : VECS[i].dep;
      check($sformatf("R2 R3 R4 R10 vec %0d pot", i), pot_n[row], VECS[i].pot * TK);
      check($sformatf("R2 R3 R4 R10 vec %0d dep", i), dep_n[row], VECS[i].dep * TK);
      check($sformatf("R6 vec %0d pause", i), pause_n, w * TK + 1);
    end

    // Multi-row event with late fire and spike injected during feedback
    run_phase('0, -1, -1, -1);
    repeat (100 * TK - 2) @(negedge clk);
    spike_wait(3, 5);
    spike_wait(1, 15);
    spike_wait(1, 10);       // R9 latest spike on row 1 wins
    spike_wait(0, 10);
    run_phase('0, 100, 50, 2);
    check("R3 row0 pot", pot_n[0], 200 * TK);
    check("R9 row1 pot latest", pot_n[1], 100 * TK);
    check("R4 row2 none", pot_n[2] + dep_n[2], 0);
    check("R3 row3 pot", pot_n[3], 20 * TK);
    check("R5 overlap cycles", both_n, 0);
    check("R8 pause length", pause_n, 200 * TK + 1);
    repeat (3) @(negedge clk);
    check("R8 no restart", int'(pause_o), 0);
    // R7 R9: ignored spike and cleared arrivals give no pulse
    run_phase('0, -1, -1, -1);
    sum = 0;
    for (int r = 0; r < NR; r++) sum += pot_n[r] + dep_n[r];
    check("R7 R9 nothing stored", sum, 0);
    check("R6 empty pause", pause_n, 1);

    // R11 interval across the timestamp wrap
    while (!((edges % TK) == 0 && ((edges / TK) % (2 ** TSW)) == (2 ** TSW) - 26))
      @(negedge clk);
    run_phase('0, -1, -1, -1);
    repeat (20 * TK - 2) @(negedge clk);
    spike_wait(0, 12);
    run_phase('0, -1, -1, -1);
    check("R11 wrap pot", pot_n[0], 200 * TK);
    check("R11 wrap dep", dep_n[0], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule